// File: doc/BRIEF.md
# Compare/Capture 16-bit Timer Channel

This block is a single timer channel built around a 16-bit up-counter. The counter advances on a tick taken from one of eight sources: the system clock divided by 1, 2, 4 or 8, or a rising edge on one of four external clock pins. Two general registers, A and B, sit beside the counter. Each one either compares against the counter and acts on its output pin when they match, or latches the counter value when a chosen edge arrives on its input pin.

Software configures the channel through a small write port. That port sets the clock source, the run bit, the counter clear source, the PWM mode, the per-register pin behaviour, the initial pin levels and the interrupt enables. A read port returns the flags, both general registers and the counter. Three sticky flags (A event, B event, overflow) drive three independently enabled interrupt lines. A trigger output pulses on every A or B event, so an external pattern generator can step on it.

Register map, by write address: 0 control (bits 2:0 source, 4:3 clear source, 5 PWM, 6 run); 1 and 2 pin configuration for A and B (bit 0 capture mode, 2:1 compare action, 4:3 capture edge, 5 initial level); 3 interrupt enables; 4 flags (write 1 to clear); 5 register A; 6 register B; 7 counter.

Top module: `cc_timer_chan`

## Requirements
- R1: Source codes 0, 1, 2 and 3 advance the running counter once every 1, 2, 4 and 8 clock cycles. Over any window whose length is a multiple of the divisor, the count equals the window length divided by the divisor.
- R2: Source codes 4 to 7 advance the running counter once for each rising edge on external clock pin 0 to 3. Falling edges and unselected pins have no effect.
- R3: A register in compare mode raises an event, and sets its flag (flag bit 0 for A, bit 1 for B), when a counter tick occurs while the counter equals the register.
- R4: Clear-source code 1 or 2 makes an A or B event (match or capture) load the counter with 0 instead of stepping it. Code 0 never clears.
- R5: On a compare event the register's pin takes the action coded 0 keep, 1 drive low, 2 drive high or 3 toggle.
- R6: Writing a pin configuration loads that pin's output with bit 5 of the written value.
- R7: A register in capture mode copies the counter when its synchronized input pin shows the selected edge (0 rising, 1 falling, 2 both) and sets its flag. Other edges are ignored.
- R8: A tick while the counter holds 0xFFFF wraps it to 0 and sets flag bit 2, unless a clear occurs.
- R9: Flags stay set until a write to address 4 with 1 in their bit position. A 0 bit leaves the flag unchanged.
- R10: Each interrupt line is high exactly when its flag is set and its enable bit (same bit position, address 3) is set.
- R11: In PWM mode, pin A goes high on an A match and low on a B match, and a B match clears the counter. When A equals B the pin stays low. Pin B's output enable is low in this mode.
- R12: The trigger output is high for one cycle after each A or B event.
- R13: After reset the counter, flags, registers, pins, interrupts and trigger are all 0.
- R14: A write to address 7 loads the counter and takes priority over a clear or a step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Read data (flags, A, B, counter) |
| ext_clk | input | 4 | External clock pins |
| pin_a_in | input | 1 | Input level of pin A |
| pin_b_in | input | 1 | Input level of pin B |
| pin_a_out | output | 1 | Output level of pin A |
| pin_a_oe | output | 1 | Output enable of pin A |
| pin_b_out | output | 1 | Output level of pin B |
| pin_b_oe | output | 1 | Output enable of pin B |
| irq_a | output | 1 | Register A interrupt |
| irq_b | output | 1 | Register B interrupt |
| irq_ovf | output | 1 | Overflow interrupt |
| trig_out | output | 1 | Event trigger pulse |

## Verification
A compare match on register A and the counter overflow can land on the same clock edge when register A holds 0xFFFF. The bench loads the counter three steps below the wrap and lets it run, while a monitor records the cycle in which each interrupt line first rises. It then requires both flags to be set and both cycle stamps to be equal. A second coincidence comes from PWM mode with A equal to B: both matches fall on the same edge, and the bench requires pin A to be low for a whole sampling window.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;

  typedef enum logic [1:0] {ACT_KEEP = 2'd0, ACT_LOW = 2'd1, ACT_HIGH = 2'd2, ACT_TOG = 2'd3} out_act_e;
  typedef enum logic [1:0] {EDG_RISE = 2'd0, EDG_FALL = 2'd1, EDG_BOTH = 2'd2, EDG_NONE = 2'd3} cap_edge_e;
  typedef enum logic [1:0] {CLR_OFF = 2'd0, CLR_ON_A = 2'd1, CLR_ON_B = 2'd2, CLR_RSV = 2'd3} clr_src_e;

  // per-register pin configuration, packed so that bit 0 is the mode bit
  typedef struct packed {
    logic      init_lvl;
    cap_edge_e edg;
    out_act_e  act;
    logic      cap;
  } io_cfg_t;

  localparam int IO_CFG_W = $bits(io_cfg_t);
  localparam int SRC_W    = 3;
  localparam int N_DIV    = 4;
  localparam int NFLG     = 3;
  localparam int FLG_A    = 0;
  localparam int FLG_B    = 1;
  localparam int FLG_OVF  = 2;

  localparam int CTL_CLR_LSB = 3;
  localparam int CTL_CLR_MSB = 4;
  localparam int CTL_PWM     = 5;
  localparam int CTL_RUN     = 6;

  localparam logic [2:0] ADR_CTRL = 3'd0;
  localparam logic [2:0] ADR_IOA  = 3'd1;
  localparam logic [2:0] ADR_IOB  = 3'd2;
  localparam logic [2:0] ADR_IEN  = 3'd3;
  localparam logic [2:0] ADR_FLAG = 3'd4;
  localparam logic [2:0] ADR_GRA  = 3'd5;
  localparam logic [2:0] ADR_GRB  = 3'd6;
  localparam logic [2:0] ADR_CNT  = 3'd7;

  function automatic logic act_apply(input out_act_e a, input logic cur);
    case (a)
      ACT_LOW:  act_apply = 1'b0;
      ACT_HIGH: act_apply = 1'b1;
      ACT_TOG:  act_apply = ~cur;
      default:  act_apply = cur;
    endcase
  endfunction

endpackage

// File: rtl/cc_edge_sync.sv
module cc_edge_sync
  import cc_timer_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  cap_edge_e edg,
  input  logic      din,
  output logic      hit
);

  logic [2:0] sh_q, sh_d;
  logic       rise, fall;

  always_comb sh_d = {sh_q[1:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise = sh_q[1] & ~sh_q[2];
  assign fall = ~sh_q[1] & sh_q[2];

  always_comb begin
    case (edg)
      EDG_RISE: hit = rise;
      EDG_FALL: hit = fall;
      EDG_BOTH: hit = rise | fall;
      default:  hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/cc_tick_gen.sv
module cc_tick_gen
  import cc_timer_pkg::*;
#(
  parameter int NDIV = 4,
  parameter int NEXT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] src,
  input  logic [NEXT-1:0]  ext_clk,
  output logic             tick
);

  localparam int PRE_W = (NDIV > 1) ? NDIV - 1 : 1;

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [NDIV-1:0]  div_tick;
  logic [NEXT-1:0]  ext_hit;

  always_comb pre_d = pre_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  for (genvar i = 0; i < NDIV; i++) begin : g_div
    if (i == 0) begin : g_one
      assign div_tick[i] = 1'b1;
    end else begin : g_pow
      assign div_tick[i] = &pre_q[i-1:0];
    end
  end

  for (genvar j = 0; j < NEXT; j++) begin : g_ext
    cc_edge_sync u_ext (
      .clk  (clk),
      .rst_n(rst_n),
      .edg  (EDG_RISE),
      .din  (ext_clk[j]),
      .hit  (ext_hit[j])
    );
  end

  always_comb begin
    tick = 1'b0;
    for (int i = 0; i < NDIV; i++)
      if (src == SRC_W'(i)) tick = div_tick[i];
    for (int j = 0; j < NEXT; j++)
      if (src == SRC_W'(NDIV + j)) tick = ext_hit[j];
  end

endmodule

// File: rtl/cc_gr_slot.sv
module cc_gr_slot
  import cc_timer_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          cap_en,
  input  cap_edge_e     edg,
  input  logic          pin_in,
  input  logic [CW-1:0] cnt,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] gr_q,
  output logic          evt
);

  logic [CW-1:0] gr_d;
  logic          pin_hit, cap_hit, cmp_hit;

  cc_edge_sync u_pin (
    .clk  (clk),
    .rst_n(rst_n),
    .edg  (edg),
    .din  (pin_in),
    .hit  (pin_hit)
  );

  assign cap_hit = cap_en & pin_hit;
  assign cmp_hit = ~cap_en & step & (cnt == gr_q);
  assign evt     = cap_hit | cmp_hit;

  always_comb begin
    gr_d = gr_q;
    if (cap_hit)    gr_d = cnt;
    else if (wr_en) gr_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gr_q <= '0;
    else        gr_q <= gr_d;
  end

endmodule

// File: rtl/cc_timer_chan.sv
module cc_timer_chan
  import cc_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int N_EXT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [2:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  input  logic [N_EXT-1:0] ext_clk,
  input  logic             pin_a_in,
  input  logic             pin_b_in,
  output logic             pin_a_out,
  output logic             pin_a_oe,
  output logic             pin_b_out,
  output logic             pin_b_oe,
  output logic             irq_a,
  output logic             irq_b,
  output logic             irq_ovf,
  output logic             trig_out
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  // write decode
  logic wr_ctrl, wr_ioa, wr_iob, wr_ien, wr_flag, wr_gra, wr_grb, wr_cnt;
  assign wr_ctrl = wr_en && (wr_addr == ADR_CTRL);
  assign wr_ioa  = wr_en && (wr_addr == ADR_IOA);
  assign wr_iob  = wr_en && (wr_addr == ADR_IOB);
  assign wr_ien  = wr_en && (wr_addr == ADR_IEN);
  assign wr_flag = wr_en && (wr_addr == ADR_FLAG);
  assign wr_gra  = wr_en && (wr_addr == ADR_GRA);
  assign wr_grb  = wr_en && (wr_addr == ADR_GRB);
  assign wr_cnt  = wr_en && (wr_addr == ADR_CNT);

  // state
  logic [SRC_W-1:0] src_q, src_d;
  clr_src_e         clr_q, clr_d;
  logic             pwm_q, pwm_d, run_q, run_d;
  io_cfg_t          cfg_a_q, cfg_a_d, cfg_b_q, cfg_b_d;
  logic [NFLG-1:0]  ien_q, ien_d, flg_q, flg_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pin_a_q, pin_a_d, pin_b_q, pin_b_d, trig_q, trig_d;

  // datapath links
  logic             tick, step, evt_a, evt_b, cap_a_en, cap_b_en;
  logic             clr_hit, ovf_hit;
  logic [CNT_W-1:0] gra_q, grb_q;
  clr_src_e         clr_eff;

  cc_tick_gen #(.NDIV(N_DIV), .NEXT(N_EXT)) u_tick (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .src    (src_q),
    .ext_clk(ext_clk),
    .tick   (tick)
  );

  assign step     = run_q & tick;
  assign cap_a_en = cfg_a_q.cap & ~pwm_q;
  assign cap_b_en = cfg_b_q.cap & ~pwm_q;

  cc_gr_slot #(.CW(CNT_W)) u_gra (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .step   (step),
    .cap_en (cap_a_en),
    .edg    (cfg_a_q.edg),
    .pin_in (pin_a_in),
    .cnt    (cnt_q),
    .wr_en  (wr_gra),
    .wr_data(wr_data),
    .gr_q   (gra_q),
    .evt    (evt_a)
  );

  cc_gr_slot #(.CW(CNT_W)) u_grb (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .step   (step),
    .cap_en (cap_b_en),
    .edg    (cfg_b_q.edg),
    .pin_in (pin_b_in),
    .cnt    (cnt_q),
    .wr_en  (wr_grb),
    .wr_data(wr_data),
    .gr_q   (grb_q),
    .evt    (evt_b)
  );

  assign clr_eff = pwm_q ? CLR_ON_B : clr_q;
  assign clr_hit = ((clr_eff == CLR_ON_A) & evt_a) | ((clr_eff == CLR_ON_B) & evt_b);
  assign ovf_hit = step & (cnt_q == '1) & ~clr_hit;

  // next state
  always_comb begin
    src_d   = src_q;
    clr_d   = clr_q;
    pwm_d   = pwm_q;
    run_d   = run_q;
    cfg_a_d = cfg_a_q;
    cfg_b_d = cfg_b_q;
    ien_d   = ien_q;
    if (wr_ctrl) begin
      src_d = wr_data[SRC_W-1:0];
      clr_d = clr_src_e'(wr_data[CTL_CLR_MSB:CTL_CLR_LSB]);
      pwm_d = wr_data[CTL_PWM];
      run_d = wr_data[CTL_RUN];
    end
    if (wr_ioa) cfg_a_d = io_cfg_t'(wr_data[IO_CFG_W-1:0]);
    if (wr_iob) cfg_b_d = io_cfg_t'(wr_data[IO_CFG_W-1:0]);
    if (wr_ien) ien_d   = wr_data[NFLG-1:0];

    // counter: software write, then clear, then step
    if (wr_cnt)       cnt_d = wr_data;
    else if (clr_hit) cnt_d = '0;
    else if (step)    cnt_d = cnt_q + 1'b1;
    else              cnt_d = cnt_q;

    // flags: a set in the same cycle as a clear write wins
    flg_d = flg_q & ~(wr_flag ? wr_data[NFLG-1:0] : '0);
    flg_d[FLG_A]   = flg_d[FLG_A]   | evt_a;
    flg_d[FLG_B]   = flg_d[FLG_B]   | evt_b;
    flg_d[FLG_OVF] = flg_d[FLG_OVF] | ovf_hit;

    // pin A
    pin_a_d = pin_a_q;
    if (wr_ioa)                   pin_a_d = wr_data[IO_CFG_W-1];
    else if (pwm_q) begin
      if (evt_b)                  pin_a_d = 1'b0;
      else if (evt_a)             pin_a_d = 1'b1;
    end else if (!cfg_a_q.cap && evt_a)
                                  pin_a_d = act_apply(cfg_a_q.act, pin_a_q);

    // pin B
    pin_b_d = pin_b_q;
    if (wr_iob)                   pin_b_d = wr_data[IO_CFG_W-1];
    else if (!pwm_q && !cfg_b_q.cap && evt_b)
                                  pin_b_d = act_apply(cfg_b_q.act, pin_b_q);

    trig_d = evt_a | evt_b;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      src_q   <= '0;
      clr_q   <= CLR_OFF;
      pwm_q   <= 1'b0;
      run_q   <= 1'b0;
      cfg_a_q <= io_cfg_t'('0);
      cfg_b_q <= io_cfg_t'('0);
      ien_q   <= '0;
      flg_q   <= '0;
      cnt_q   <= '0;
      pin_a_q <= 1'b0;
      pin_b_q <= 1'b0;
      trig_q  <= 1'b0;
    end else begin
      src_q   <= src_d;
      clr_q   <= clr_d;
      pwm_q   <= pwm_d;
      run_q   <= run_d;
      cfg_a_q <= cfg_a_d;
      cfg_b_q <= cfg_b_d;
      ien_q   <= ien_d;
      flg_q   <= flg_d;
      cnt_q   <= cnt_d;
      pin_a_q <= pin_a_d;
      pin_b_q <= pin_b_d;
      trig_q  <= trig_d;
    end
  end

  // outputs
  assign pin_a_out = pin_a_q;
  assign pin_b_out = pin_b_q;
  assign pin_a_oe  = pwm_q | ~cfg_a_q.cap;
  assign pin_b_oe  = ~pwm_q & ~cfg_b_q.cap;
  assign irq_a     = flg_q[FLG_A]   & ien_q[FLG_A];
  assign irq_b     = flg_q[FLG_B]   & ien_q[FLG_B];
  assign irq_ovf   = flg_q[FLG_OVF] & ien_q[FLG_OVF];
  assign trig_out  = trig_q;

  always_comb begin
    case (rd_addr)
      ADR_FLAG: rd_data = CNT_W'(flg_q);
      ADR_GRA:  rd_data = gra_q;
      ADR_GRB:  rd_data = grb_q;
      ADR_CNT:  rd_data = cnt_q;
      default:  rd_data = '0;
    endcase
  end

endmodule

// File: rtl/cc_timer_chan_chk.sv
module cc_timer_chan_chk
  import cc_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_i_n,
  input logic             wr_en,
  input logic [2:0]       wr_addr,
  input logic [NFLG-1:0]  flg_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] gra_q,
  input logic [CNT_W-1:0] grb_q,
  input logic             trig_out,
  input logic             pin_a_out,
  input logic             pwm_q,
  input logic             run_q,
  input logic             evt_a,
  input logic             evt_b,
  input logic             cap_a_en,
  input logic             cap_b_en
);

  // R9: a flag only falls after a flag-clear write
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_i_n)
    (|($past(flg_q) & ~flg_q)) |-> $past(wr_en && (wr_addr == ADR_FLAG)));

  // R8: overflow flag rises only after the counter held all ones
  a_r8_ovf_from_max: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(flg_q[FLG_OVF]) |-> ($past(cnt_q) == '1));

  // R7: a capture event on A stores the counter value seen in that cycle
  a_r7_capture_a: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cap_a_en && evt_a) |=> (gra_q == $past(cnt_q)));

  // R7: same for B
  a_r7_capture_b: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cap_b_en && evt_b) |=> (grb_q == $past(cnt_q)));

  // R12: a trigger pulse is always accompanied by a set event flag
  a_r12_trig_flag: assert property (@(posedge clk) disable iff (!rst_i_n)
    trig_out |-> (flg_q[FLG_A] || flg_q[FLG_B]));

  // R11: in PWM mode the pin rises only on an A match without a B match
  a_r11_pwm_rise: assert property (@(posedge clk) disable iff (!rst_i_n)
    (pwm_q && $past(pwm_q) && $rose(pin_a_out) && !$past(wr_en && (wr_addr == ADR_IOA)))
      |-> $past(evt_a && !evt_b));

  // R14: a stopped counter with no write keeps its value or is cleared
  a_r14_hold: assert property (@(posedge clk) disable iff (!rst_i_n)
    $past(!run_q && !(wr_en && (wr_addr == ADR_CNT))) |-> ((cnt_q == $past(cnt_q)) || (cnt_q == '0)));

endmodule

bind cc_timer_chan cc_timer_chan_chk #(.CNT_W(CNT_W)) chk_i (
  .clk      (clk),
  .rst_i_n  (rst_i_n),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .flg_q    (flg_q),
  .cnt_q    (cnt_q),
  .gra_q    (gra_q),
  .grb_q    (grb_q),
  .trig_out (trig_out),
  .pin_a_out(pin_a_out),
  .pwm_q    (pwm_q),
  .run_q    (run_q),
  .evt_a    (evt_a),
  .evt_b    (evt_b),
  .cap_a_en (cap_a_en),
  .cap_b_en (cap_b_en)
);

// File: tb/cc_timer_chan_tb_top.sv
module cc_timer_chan_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, wr_en;
  logic [2:0]  wr_addr, rd_addr;
  logic [15:0] wr_data, rd_data;
  logic [3:0]  ext_clk;
  logic        pin_a_in, pin_b_in;
  logic        pin_a_out, pin_a_oe, pin_b_out, pin_b_oe;
  logic        irq_a, irq_b, irq_ovf, trig_out;

  cc_timer_chan dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ext_clk(ext_clk),
    .pin_a_in(pin_a_in), .pin_b_in(pin_b_in),
    .pin_a_out(pin_a_out), .pin_a_oe(pin_a_oe), .pin_b_out(pin_b_out), .pin_b_oe(pin_b_oe),
    .irq_a(irq_a), .irq_b(irq_b), .irq_ovf(irq_ovf), .trig_out(trig_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // scoreboard
  typedef struct {
    string       req;
    logic [31:0] act;
    logic [31:0] exp;
  } item_t;

  item_t q[$];
  int    total = 0;
  int    bad   = 0;
  bit    done  = 0;

  // observation counters filled by the monitor
  bit mon_on = 0;
  int trig_cnt = 0, high_cnt = 0;
  int cyc = 0, cyc_a = 0, cyc_ovf = 0;

  always @(negedge clk) begin
    #2;
    cyc++;
    if (mon_on) begin
      trig_cnt += int'(trig_out);
      high_cnt += int'(pin_a_out);
    end
    if (irq_a   && cyc_a   == 0) cyc_a   = cyc;
    if (irq_ovf && cyc_ovf == 0) cyc_ovf = cyc;
  end

  always @(negedge clk) begin
    #3;
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      total++;
      if (it.act !== it.exp) begin
        bad++;
        $display("FAIL %s act=%0h exp=%0h", it.req, it.act, it.exp);
      end
    end
  end

  task automatic expect_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    item_t it;
    it.req = req; it.act = act; it.exp = exp;
    q.push_back(it);
  endtask

  // driver tasks, called at a falling edge
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic run_for(input logic [15:0] ctl, input int m);
    wr(3'd0, ctl | 16'h0040);
    repeat (m) @(negedge clk);
    wr(3'd0, ctl & ~16'h0040);
  endtask

  task automatic finish_run();
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    ext_clk = '0; pin_a_in = 1'b0; pin_b_in = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R13 reset state
    rd(3'd7, v); expect_eq("R13 cnt", v, 0);
    rd(3'd4, v); expect_eq("R13 flags", v, 0);
    rd(3'd5, v); expect_eq("R13 gra", v, 0);
    rd(3'd6, v); expect_eq("R13 grb", v, 0);
    expect_eq("R13 pins", {pin_a_out, pin_b_out}, 0);
    expect_eq("R13 irq/trig", {irq_a, irq_b, irq_ovf, trig_out}, 0);

    // R1 internal prescaler: windows of m+1 edges
    wr(3'd7, 0); run_for(16'h0000, 19); rd(3'd7, v); expect_eq("R1 div1", v, 20);
    wr(3'd7, 0); run_for(16'h0001, 19); rd(3'd7, v); expect_eq("R1 div2", v, 10);
    wr(3'd7, 0); run_for(16'h0002, 39); rd(3'd7, v); expect_eq("R1 div4", v, 10);
    wr(3'd7, 0); run_for(16'h0003, 79); rd(3'd7, v); expect_eq("R1 div8", v, 10);

    // R2 external pin 2 selected, pin 1 ignored
    wr(3'd7, 0);
    wr(3'd0, 16'h0046);
    for (int k = 0; k < 5; k++) begin
      ext_clk = 4'b0110; repeat (3) @(negedge clk);
      ext_clk = 4'b0000; repeat (3) @(negedge clk);
    end
    repeat (5) @(negedge clk);
    wr(3'd0, 16'h0006);
    rd(3'd7, v); expect_eq("R2 ext rises", v, 5);

    // R3 R4 R5 R12 R10: A compare toggle, clear on A, period 5
    wr(3'd2, 16'h0001);
    wr(3'd1, 16'h0026);
    expect_eq("R6 init high A", pin_a_out, 1);
    wr(3'd5, 4);
    wr(3'd3, 16'h0001);
    wr(3'd4, 16'h0007);
    wr(3'd7, 0);
    trig_cnt = 0; mon_on = 1;
    run_for(16'h0008, 22);
    repeat (3) @(negedge clk);
    mon_on = 0;
    rd(3'd7, v); expect_eq("R4 clear on A", v, 3);
    expect_eq("R5 toggle x4", pin_a_out, 1);
    expect_eq("R12 trig pulses", trig_cnt, 4);
    rd(3'd4, v); expect_eq("R3 flag A", v, 1);
    expect_eq("R10 irq a on, b off", {irq_a, irq_b}, 2'b10);

    // R8 with A match on the same edge
    wr(3'd1, 16'h0000);
    wr(3'd5, 16'hFFFF);
    wr(3'd4, 16'h0007);
    wr(3'd3, 16'h0007);
    wr(3'd7, 16'hFFFD);
    cyc_a = 0; cyc_ovf = 0;
    run_for(16'h0000, 4);
    rd(3'd7, v); expect_eq("R8 wrap", v, 2);
    rd(3'd4, v); expect_eq("R8 flags A+ovf", v, 5);
    expect_eq("R8 same cycle", (cyc_a == cyc_ovf) && (cyc_a != 0), 1);

    // R9 write-1-clear
    wr(3'd4, 16'h0001); rd(3'd4, v); expect_eq("R9 clear A only", v, 4);
    wr(3'd4, 16'h0000); rd(3'd4, v); expect_eq("R9 zero write", v, 4);
    wr(3'd4, 16'h0004); rd(3'd4, v); expect_eq("R9 clear ovf", v, 0);
    expect_eq("R10 irq ovf off", irq_ovf, 0);

    // R5 drive high / drive low on B
    wr(3'd2, 16'h0004);
    expect_eq("R6 init low B", pin_b_out, 0);
    wr(3'd6, 2); wr(3'd7, 0);
    run_for(16'h0000, 9);
    expect_eq("R5 drive high", pin_b_out, 1);
    wr(3'd2, 16'h0022);
    expect_eq("R6 init high B", pin_b_out, 1);
    wr(3'd7, 0);
    run_for(16'h0000, 9);
    expect_eq("R5 drive low", pin_b_out, 0);

    // R7 capture on A with edge selection, counter stopped
    wr(3'd4, 16'h0007);
    wr(3'd1, 16'h0001);
    wr(3'd7, 16'h1234);
    pin_a_in = 1'b1; repeat (4) @(negedge clk);
    rd(3'd5, v); expect_eq("R7 rise capture", v, 16'h1234);
    rd(3'd4, v); expect_eq("R7 flag A", v, 1);
    wr(3'd4, 16'h0007);
    wr(3'd7, 16'h0555);
    pin_a_in = 1'b0; repeat (4) @(negedge clk);
    rd(3'd5, v); expect_eq("R7 fall ignored", v, 16'h1234);
    rd(3'd4, v); expect_eq("R7 no flag", v, 0);
    wr(3'd1, 16'h0009);
    pin_a_in = 1'b1; repeat (4) @(negedge clk);
    rd(3'd5, v); expect_eq("R7 rise ignored", v, 16'h1234);
    pin_a_in = 1'b0; repeat (4) @(negedge clk);
    rd(3'd5, v); expect_eq("R7 fall capture", v, 16'h0555);
    wr(3'd1, 16'h0011);
    wr(3'd7, 16'h0777);
    pin_a_in = 1'b1; repeat (4) @(negedge clk);
    rd(3'd5, v); expect_eq("R7 both capture", v, 16'h0777);

    // R4 clear on B capture, R10 enable gating
    wr(3'd4, 16'h0007);
    wr(3'd3, 16'h0001);
    wr(3'd2, 16'h0011);
    wr(3'd0, 16'h0010);
    wr(3'd7, 16'h0ABC);
    pin_b_in = 1'b1; repeat (4) @(negedge clk);
    rd(3'd6, v); expect_eq("R4 capture B value", v, 16'h0ABC);
    rd(3'd7, v); expect_eq("R4 clear on B capture", v, 0);
    expect_eq("R10 irq b masked", irq_b, 0);
    wr(3'd3, 16'h0003);
    expect_eq("R10 irq b enabled", irq_b, 1);

    // R11 PWM: A=2, B=5, period 6, high 3
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'h0000); wr(3'd2, 16'h0000);
    wr(3'd5, 2); wr(3'd6, 5); wr(3'd7, 0);
    wr(3'd0, 16'h0060);
    repeat (20) @(negedge clk);
    high_cnt = 0; mon_on = 1;
    repeat (60) @(negedge clk);
    mon_on = 0;
    expect_eq("R11 pwm duty", high_cnt, 30);
    expect_eq("R11 oe a/b", {pin_a_oe, pin_b_oe}, 2'b10);
    // A equal to B keeps the pin low
    wr(3'd0, 16'h0020);
    wr(3'd7, 0); wr(3'd5, 3); wr(3'd6, 3);
    wr(3'd0, 16'h0060);
    repeat (20) @(negedge clk);
    high_cnt = 0; mon_on = 1;
    repeat (60) @(negedge clk);
    mon_on = 0;
    expect_eq("R11 equal stays low", high_cnt, 0);
    wr(3'd0, 16'h0000);

    // R14 counter write
    wr(3'd7, 16'hBEEF);
    rd(3'd7, v); expect_eq("R14 cnt load", v, 16'hBEEF);

    done = 1;
    finish_run();
  end

endmodule